// File: doc/BRIEF.md
# Double-Buffered Frequency Control Register Port

This block is the write-only byte-wide processor port of a numerically controlled oscillator. A host writes one byte at a time into a working (master) register set through an 8-bit data bus, a 4-bit address, a write strobe and a write enable. The master set holds a 48-bit center frequency word, a 48-bit offset frequency word and a two-bit control byte. None of these values reaches the oscillator until an active-low commit input copies the whole master set into the live (slave) set in one clock. A multi-byte frequency word therefore changes all at once, even when the host writes it slowly.

The strobe may be asynchronous to the oscillator clock. It is synchronized into the clock domain, and its rising edge is detected there. The bus fields are sampled at the same clock edge that first sees the strobe high. Extra pipeline stages fix the latency from a write to the outputs at 11 clocks when commit is held low, and at 14 clocks from the assertion of commit. While commit is held low, each byte passes straight through to the outputs, so a partly written word can be seen there.

Top module: `fcw_shadow_regs`

## Requirements
- R1: An active-low reset sets every output to zero and discards writes still in flight. No output changes afterwards until a new write arrives.
- R2: Addresses 0 to 5 write center word bits [8n+7:8n] for address n. Addresses 6 to 11 write offset word bits [8n+7:8n] for address 6+n. Address 12 is the control byte: data bit 0 drives zero_center, data bit 1 drives zero_serial, and all other bits are dropped.
- R3: While commit_n is high, writes change only the master set, and the outputs hold their values.
- R4: With commit_n held low, a written byte appears at the outputs exactly 11 clock edges after the first edge that samples bus_wr high. It does not appear one edge earlier.
- R5: When commit_n goes low, the outputs take the full master set exactly 14 edges after the first edge that samples it low. Holding commit_n low for a single sampled edge is enough.
- R6: A write whose bus_wr_en is low at the sampling edge is ignored, and so is a write to addresses 13 to 15.
- R7: Writes spaced two clocks apart (strobe high for one edge, low for the next) are each captured.
- R8: A strobe held high for many clocks makes exactly one write, using the bus value from the first edge that sees it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Write data byte |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe; its rising edge starts a write |
| bus_wr_en | input | 1 | Write enable, active high |
| commit_n | input | 1 | Active-low commit of master set to live set |
| center_word | output | 48 | Live center frequency word |
| offset_word | output | 48 | Live offset frequency word |
| zero_center | output | 1 | Live control bit: suppress center term |
| zero_serial | output | 1 | Live control bit: suppress serial term |

## Verification
The bench samples the outputs one edge before and exactly at each specified latency, so a pipeline that is one stage short or one stage long fails at once. It writes a full word at the fastest strobe rate while commit is released. This catches a design that lets bytes leak to the outputs early, or one whose edge detector merges back-to-back strobes. It holds the strobe high while the data changes, which catches a design that is level-sensitive or samples the bus late. It also resets with a write still in the pipeline, which catches a design that clears only the visible registers and lets the stale byte land later.

// File: rtl/fcw_shadow_regs.sv
module fcw_shadow_regs #(
  parameter int WORD_BYTES = 6,
  parameter int ADDR_W     = 4,
  parameter int WRITE_LAT  = 11,
  parameter int COMMIT_LAT = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              bus_data,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_wr_en,
  input  logic                    commit_n,
  output logic [8*WORD_BYTES-1:0] center_word,
  output logic [8*WORD_BYTES-1:0] offset_word,
  output logic                    zero_center,
  output logic                    zero_serial
);
  localparam int WORD_W    = 8 * WORD_BYTES;
  localparam int BUS_W     = 1 + ADDR_W + 8;
  localparam int WPIPE     = WRITE_LAT - 3;
  localparam int UPIPE     = COMMIT_LAT - 2;
  localparam int CTRL_ADDR = 2 * WORD_BYTES;

  logic [2:0]                   wr_sync;
  logic [BUS_W-1:0]             bus_s1, bus_s2;
  logic [WPIPE-1:0][BUS_W-1:0]  wpipe;
  logic [1:0]                   cm_sync;
  logic [UPIPE-1:0]             cm_pipe;
  logic [WORD_W-1:0]            m_ctr, m_off, s_ctr, s_off;
  logic [1:0]                   m_ctl, s_ctl;

  wire              wr_edge = wr_sync[1] & ~wr_sync[2];
  wire [BUS_W-1:0]  w_last  = wpipe[WPIPE-1];
  wire              w_vld   = w_last[BUS_W-1];
  wire [ADDR_W-1:0] w_addr  = w_last[BUS_W-2 -: ADDR_W];
  wire [7:0]        w_data  = w_last[7:0];
  wire              load    = cm_pipe[UPIPE-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sync <= '0;
      bus_s1  <= '0;
      bus_s2  <= '0;
      wpipe   <= '0;
      cm_sync <= '0;
      cm_pipe <= '0;
    end else begin
      wr_sync <= {wr_sync[1:0], bus_wr};
      bus_s1  <= {bus_wr_en, bus_addr, bus_data};
      bus_s2  <= bus_s1;
      wpipe   <= {wpipe[WPIPE-2:0], {wr_edge & bus_s2[BUS_W-1], bus_s2[BUS_W-2:0]}};
      cm_sync <= {cm_sync[0], ~commit_n};
      cm_pipe <= {cm_pipe[UPIPE-2:0], cm_sync[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctr <= '0;
      m_off <= '0;
      m_ctl <= '0;
    end else if (w_vld) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (w_addr == ADDR_W'(b))              m_ctr[8*b +: 8] <= w_data;
        if (w_addr == ADDR_W'(b + WORD_BYTES)) m_off[8*b +: 8] <= w_data;
      end
      if (w_addr == ADDR_W'(CTRL_ADDR)) m_ctl <= w_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ctr <= '0;
      s_off <= '0;
      s_ctl <= '0;
    end else if (load) begin
      s_ctr <= m_ctr;
      s_off <= m_off;
      s_ctl <= m_ctl;
    end
  end

  assign center_word = s_ctr;
  assign offset_word = s_off;
  assign zero_center = s_ctl[0];
  assign zero_serial = s_ctl[1];
endmodule

module fcw_shadow_regs_chk #(
  parameter int WORD_BYTES = 6,
  parameter int WRITE_LAT  = 11,
  parameter int COMMIT_LAT = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic                    commit_n,
  input logic [8*WORD_BYTES-1:0] center_word,
  input logic [8*WORD_BYTES-1:0] offset_word,
  input logic                    zero_center,
  input logic                    zero_serial
);
  localparam int CMAX  = COMMIT_LAT + WRITE_LAT + 3;
  localparam int CNT_W = $clog2(CMAX + 1) + 1;

  wire [16*WORD_BYTES+1:0] obs = {center_word, offset_word, zero_serial, zero_center};
  logic [CNT_W-1:0]   hi_cnt, lo_cnt;
  logic               quiet, wr_prev;
  logic [WRITE_LAT:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      quiet   <= 1'b0;
      wr_prev <= 1'b0;
      hist    <= '0;
    end else begin
      wr_prev <= bus_wr;
      hist    <= {hist[WRITE_LAT-1:0], bus_wr & ~wr_prev};
      if (commit_n) begin
        lo_cnt <= '0;
        if (hi_cnt != CNT_W'(CMAX)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt == '0) quiet <= (hi_cnt >= CNT_W'(COMMIT_LAT));
        if (lo_cnt != CNT_W'(CMAX)) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> obs == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(obs) |-> hi_cnt <= CNT_W'(COMMIT_LAT));

  p_write_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(obs) && lo_cnt >= CNT_W'(COMMIT_LAT + 2)) |-> hist[WRITE_LAT]);

  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt >= CNT_W'(COMMIT_LAT + 2) && hist == '0) |-> $stable(obs));

  p_commit_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(obs) && quiet && lo_cnt != '0) |-> lo_cnt >= CNT_W'(COMMIT_LAT + 1));
endmodule

bind fcw_shadow_regs fcw_shadow_regs_chk #(
  .WORD_BYTES(WORD_BYTES),
  .WRITE_LAT (WRITE_LAT),
  .COMMIT_LAT(COMMIT_LAT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .commit_n   (commit_n),
  .center_word(center_word),
  .offset_word(offset_word),
  .zero_center(zero_center),
  .zero_serial(zero_serial)
);

// File: tb/fcw_shadow_regs_tb.sv
`timescale 1ns/1ps
module fcw_shadow_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_data = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        commit_n = 1'b1;
  logic [47:0] center_word, offset_word;
  logic        zero_center, zero_serial;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fcw_shadow_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wr_en(bus_wr_en), .commit_n(commit_n),
    .center_word(center_word), .offset_word(offset_word),
    .zero_center(zero_center), .zero_serial(zero_serial)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic [7:0]  d;
    logic        en;
    logic [47:0] c;
    logic [47:0] o;
    logic [1:0]  z;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  8'h11, 1'b1, 48'h0000_0000_0011, 48'h0000_0000_0000, 2'b00},
    '{4'd5,  8'hA5, 1'b1, 48'hA500_0000_0011, 48'h0000_0000_0000, 2'b00},
    '{4'd6,  8'h3C, 1'b1, 48'hA500_0000_0011, 48'h0000_0000_003C, 2'b00},
    '{4'd11, 8'hF0, 1'b1, 48'hA500_0000_0011, 48'hF000_0000_003C, 2'b00},
    '{4'd13, 8'hFF, 1'b1, 48'hA500_0000_0011, 48'hF000_0000_003C, 2'b00},
    '{4'd2,  8'h77, 1'b0, 48'hA500_0000_0011, 48'hF000_0000_003C, 2'b00},
    '{4'd12, 8'hFF, 1'b1, 48'hA500_0000_0011, 48'hF000_0000_003C, 2'b11},
    '{4'd12, 8'h02, 1'b1, 48'hA500_0000_0011, 48'hF000_0000_003C, 2'b10},
    '{4'd3,  8'hC4, 1'b1, 48'hA500_C400_0011, 48'hF000_0000_003C, 2'b10},
    '{4'd15, 8'h12, 1'b1, 48'hA500_C400_0011, 48'hF000_0000_003C, 2'b10}
  };

  function automatic logic [97:0] obs();
    return {center_word, offset_word, zero_serial, zero_center};
  endfunction

  task automatic check(input string tag, input logic [97:0] act, input logic [97:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic timed_write(input logic [3:0] a, input logic [7:0] d, input logic en,
                             input logic [97:0] old_v, input logic [97:0] new_v, input string tag);
    bus_addr = a; bus_data = d; bus_wr_en = en; bus_wr = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 3) bus_wr = 1'b0;
      if (i == 11) check({"R4 early ", tag}, obs(), old_v);
      if (i == 12) check(tag, obs(), new_v);
    end
  endtask

  task automatic fast_write(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_data = d; bus_wr_en = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [97:0] prev;
    logic [97:0] nxt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", obs(), '0);

    commit_n = 1'b0;
    repeat (20) @(negedge clk);

    // R2 map, R4 pass-through latency, R6 ignored writes (vectors 4, 5, 9)
    prev = '0;
    for (int v = 0; v < NV; v++) begin
      string tag;
      nxt = {VECS[v].c, VECS[v].o, VECS[v].z};
      tag = (!VECS[v].en || VECS[v].a > 4'd12) ? $sformatf("R6 vec%0d", v)
                                               : $sformatf("R2 R4 vec%0d", v);
      timed_write(VECS[v].a, VECS[v].d, VECS[v].en, prev, nxt, tag);
      repeat (2) @(negedge clk);
      prev = nxt;
    end

    // R8: strobe held high, data changes mid-pulse
    bus_addr = 4'd1; bus_data = 8'h5A; bus_wr_en = 1'b1; bus_wr = 1'b1;
    repeat (3) @(negedge clk);
    bus_data = 8'hEE;
    repeat (20) @(negedge clk);
    bus_wr = 1'b0;
    repeat (20) @(negedge clk);
    prev = {48'hA500_C400_5A11, 48'hF000_0000_003C, 2'b10};
    check("R8 single write on long strobe", obs(), prev);

    // R3 hold while released, R7 back-to-back writes
    commit_n = 1'b1;
    repeat (20) @(negedge clk);
    fast_write(4'd0, 8'hAB);
    fast_write(4'd1, 8'h89);
    fast_write(4'd2, 8'h67);
    fast_write(4'd3, 8'h45);
    fast_write(4'd4, 8'h23);
    fast_write(4'd5, 8'h01);
    fast_write(4'd6, 8'h77);
    repeat (30) @(negedge clk);
    check("R3 outputs held while commit released", obs(), prev);

    // R5: single-cycle commit pulse, 14-edge latency
    nxt = {48'h0123_4567_89AB, 48'hF000_0000_0077, 2'b10};
    commit_n = 1'b0;
    for (int i = 1; i <= 15; i++) begin
      @(negedge clk);
      if (i == 1) commit_n = 1'b1;
      if (i == 14) check("R5 early", obs(), prev);
      if (i == 15) check("R5 R7 commit", obs(), nxt);
    end
    repeat (5) @(negedge clk);

    // R1: reset with a write in flight
    commit_n = 1'b0;
    repeat (20) @(negedge clk);
    bus_addr = 4'd12; bus_data = 8'h01; bus_wr_en = 1'b1; bus_wr = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset clears outputs", obs(), '0);
    rst_n = 1'b1;
    repeat (25) @(negedge clk);
    check("R1 in-flight write discarded", obs(), '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule